// File: doc/BRIEF.md
# Timing-Recovery Proportional-Integral Loop Filter

This block is the loop compensation stage of a timing-recovery phase-locked loop. Each cycle in which a strobe marks a phase-error sample as valid, the signed error is first scaled by a selectable detector gain. The filter then forms two terms from it. The proportional term is a left-shifted copy of the scaled error. The integral term adds a right-shifted copy of the scaled error into a saturating accumulator. The registered sum of the two terms is a signed frequency-control word for a numerically controlled oscillator.

All coefficients are powers of two, so every gain is an arithmetic shift and the block has no multipliers. A 5-bit control word carries three fields. A 2-bit loop-gain code selects the proportional and integral shifts as a pair. A 2-bit detector-gain code selects the error scaling. A hold bit freezes the loop: while it is high, the proportional path contributes nothing and the accumulator does not move, so the oscillator stays at the last integrated frequency. The detector, the oscillator and the register file that holds the control word are outside this block.

Top module: `pi_loop_filter`

## Requirements
- R1: While `rst_n` is low, at each rising clock edge both `freq_word` and the internal accumulator are cleared to zero.
- R2: Detector-gain code `ctrl_word[3:2]` multiplies the error as follows: 00 gives x1, 01 gives x2 and 10 gives x4. The result is the scaled error `es`.
- R3: Detector-gain code 11 is unused and scales exactly like code 00 (x1).
- R4: Loop-gain code `ctrl_word[1:0]` sets the proportional term to `es` shifted left by 0, 2, 4 or 6 bits for codes 00, 01, 10 and 11.
- R5: The same loop-gain code sets the integral increment to `es` arithmetically shifted right by 12, 8, 5 or 0 bits for codes 00, 01, 10 and 11. The shift rounds toward minus infinity.
- R6: On a valid sample with the hold bit `ctrl_word[4]` low, the accumulator becomes sat(acc + increment). In the next cycle, `freq_word` shows sat(proportional + new accumulator). If there is no valid sample and the hold bit is low, `freq_word` keeps its value. Gains are taken from the cycle of the sample.
- R7: In the cycle after any cycle in which `ctrl_word[4]` is high, `freq_word` equals the accumulator. The proportional contribution is zero.
- R8: While `ctrl_word[4]` is high, valid samples leave the accumulator unchanged.
- R9: When `ctrl_word[4]` returns low, valid samples again update the accumulator and add the proportional term.
- R10: The accumulator saturates at -2^(ACC_W-1) and 2^(ACC_W-1)-1 and never wraps.
- R11: `freq_word` saturates at the same signed limits when the proportional term and the accumulator overflow together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | Marks `err_in` as a new phase-error sample |
| err_in | input | ERR_W | Signed phase error |
| ctrl_word | input | 5 | [4] hold, [3:2] detector gain, [1:0] loop gain |
| freq_word | output | ACC_W | Signed frequency-control word |

## Verification
The hold bit and a valid error sample can arrive in the same cycle. The hold must win: the sample must change neither the accumulator nor the output, and the output must fall back to the bare accumulator. The bench provokes this with directed sample bursts at full loop gain while the hold is high, and again with a freeze probability mixed into random traffic. A reference model computes the expected word, and the output is checked in the following cycle. A second collision is accumulator saturation coinciding with output saturation. A long run of full-scale errors drives both into their positive and then their negative limits, and the bench compares them against the clamped model values.

// File: rtl/pi_loop_pkg.sv
// Package: shared control-word layout and gain-code decoding for the
// proportional-integral loop filter. Assumes all coefficients are powers of two.
package pi_loop_pkg;

    // Control word fields; the bit positions are fixed by the register file.
    typedef struct packed {
        logic       hold;      // bit 4
        logic [1:0] pd_gain;   // bits 3:2
        logic [1:0] loop_gain; // bits 1:0
    } pi_ctrl_t;

    localparam int unsigned PD_MAX_SHIFT   = 2;
    localparam int unsigned PROP_MAX_SHIFT = 6;

    // Detector gain: x1, x2, x4; the unused code falls back to x1.
    function automatic int unsigned pd_shift(input logic [1:0] code);
        case (code)
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 0;
        endcase
    endfunction

    // Proportional left shift grows with loop gain.
    function automatic int unsigned prop_shift(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    // Integral right shift shrinks with loop gain.
    function automatic int unsigned int_shift(input logic [1:0] code);
        case (code)
            2'b00:   return 12;
            2'b01:   return 8;
            2'b10:   return 5;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pi_err_scaler.sv
// Module: pi_err_scaler
// Scales the raw phase error by the detector gain, which is a left shift by
// 0 to 2 bits. The output is wide enough that no scaling can overflow.
module pi_err_scaler #(
    parameter int ERR_W = 12,
    localparam int ES_W = ERR_W + pi_loop_pkg::PD_MAX_SHIFT
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic [1:0]              pd_code,
    output logic signed [ES_W-1:0]  es
);
    import pi_loop_pkg::*;

    logic signed [ES_W-1:0] err_ext;

    // Sign-extend the error, then shift it by the decoded detector gain.
    always_comb begin
        err_ext = {{PD_MAX_SHIFT{err[ERR_W-1]}}, err};
        es      = err_ext <<< pd_shift(pd_code);
    end
endmodule

// File: rtl/pi_prop_path.sv
// Module: pi_prop_path
// Forms the proportional term from the scaled error. The term is forced to
// zero while the loop is held. The output width covers the largest shift.
module pi_prop_path #(
    parameter int ES_W = 14,
    localparam int P_W = ES_W + pi_loop_pkg::PROP_MAX_SHIFT
) (
    input  logic signed [ES_W-1:0] es,
    input  logic [1:0]             loop_code,
    input  logic                   hold,
    output logic signed [P_W-1:0]  prop
);
    import pi_loop_pkg::*;

    logic signed [P_W-1:0] es_ext;

    // Shift the extended error by the proportional coefficient, or zero it.
    always_comb begin
        es_ext = {{PROP_MAX_SHIFT{es[ES_W-1]}}, es};
        prop   = hold ? '0 : (es_ext <<< prop_shift(loop_code));
    end
endmodule

// File: rtl/pi_integrator.sv
// Module: pi_integrator
// Saturating integral accumulator. It adds the scaled error, right-shifted by
// the integral coefficient, whenever upd is high. It assumes ACC_W > ES_W.
// acc_d is the value the accumulator takes at the next edge.
module pi_integrator #(
    parameter int ES_W  = 14,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [ES_W-1:0]  es,
    input  logic [1:0]              loop_code,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] acc_d
);
    import pi_loop_pkg::*;

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W-1:0] es_ext;
    logic signed [ACC_W-1:0] inc;
    logic signed [ACC_W:0]   sum;
    logic signed [ACC_W-1:0] sat_sum;

    // Integral increment: the scaled error divided by the coefficient (floor).
    always_comb begin
        es_ext = {{(ACC_W-ES_W){es[ES_W-1]}}, es};
        inc    = es_ext >>> int_shift(loop_code);
    end

    // One-bit-wider sum, clamped back into range when the top two bits differ.
    always_comb begin
        sum = {acc_q[ACC_W-1], acc_q} + {inc[ACC_W-1], inc};
        if (sum[ACC_W] != sum[ACC_W-1])
            sat_sum = sum[ACC_W] ? ACC_MIN : ACC_MAX;
        else
            sat_sum = sum[ACC_W-1:0];
        acc_d = upd ? sat_sum : acc_q;
    end

    // Accumulator register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/pi_loop_filter.sv
// Module: pi_loop_filter (top)
// Proportional-integral loop compensation filter for timing recovery. It
// scales each valid error sample, updates the saturating integrator and
// registers sat(proportional + accumulator) as the frequency word. When the
// hold bit is set, the output loads the bare accumulator and nothing integrates.
// Assumes a single clock domain and the control word stable around samples.
module pi_loop_filter #(
    parameter int ERR_W = 12,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic [4:0]              ctrl_word,
    output logic signed [ACC_W-1:0] freq_word
);
    import pi_loop_pkg::*;

    localparam int ES_W = ERR_W + PD_MAX_SHIFT;
    localparam int P_W  = ES_W + PROP_MAX_SHIFT;
    localparam logic signed [ACC_W-1:0] OUT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] OUT_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    pi_ctrl_t                ctrl;
    logic signed [ES_W-1:0]  es;
    logic signed [P_W-1:0]   prop;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    logic                    upd;
    logic signed [ACC_W:0]   out_sum;
    logic signed [ACC_W-1:0] out_sat;

    // Unpack the control word into its named fields.
    always_comb ctrl = pi_ctrl_t'(ctrl_word);

    // The integrator moves only on a valid sample while the loop is not held.
    always_comb upd = err_valid && !ctrl.hold;

    pi_err_scaler #(.ERR_W(ERR_W)) u_scaler (
        .err     (err_in),
        .pd_code (ctrl.pd_gain),
        .es      (es)
    );

    pi_prop_path #(.ES_W(ES_W)) u_prop (
        .es        (es),
        .loop_code (ctrl.loop_gain),
        .hold      (ctrl.hold),
        .prop      (prop)
    );

    pi_integrator #(.ES_W(ES_W), .ACC_W(ACC_W)) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .es        (es),
        .loop_code (ctrl.loop_gain),
        .acc_q     (acc_q),
        .acc_d     (acc_d)
    );

    // Add the proportional term to the updated accumulator and clamp the sum.
    always_comb begin
        out_sum = {{(ACC_W+1-P_W){prop[P_W-1]}}, prop} + {acc_d[ACC_W-1], acc_d};
        if (out_sum[ACC_W] != out_sum[ACC_W-1])
            out_sat = out_sum[ACC_W] ? OUT_MIN : OUT_MAX;
        else
            out_sat = out_sum[ACC_W-1:0];
    end

    // Output register: the hold bit loads the accumulator, a sample loads the sum.
    always_ff @(posedge clk) begin
        if (!rst_n)           freq_word <= '0;
        else if (ctrl.hold)   freq_word <= acc_q;
        else if (err_valid)   freq_word <= out_sat;
    end
endmodule

// File: rtl/pi_loop_filter_checker.sv
// Module: pi_loop_filter_checker
// Temporal properties of the loop filter, bound to the top module.
module pi_loop_filter_checker #(
    parameter int ERR_W = 12,
    parameter int ACC_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    err_valid,
    input logic signed [ERR_W-1:0] err_in,
    input logic [4:0]              ctrl_word,
    input logic signed [ACC_W-1:0] freq_word,
    input logic signed [ACC_W-1:0] acc_q
);
    localparam logic signed [ACC_W-1:0] LIM_HI = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LIM_LO = {1'b1, {(ACC_W-1){1'b0}}};

    // R1: reset clears output and accumulator
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (freq_word == '0 && acc_q == '0));

    // R6: no sample and no hold leaves the output unchanged
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_valid && !ctrl_word[4]) |=> $stable(freq_word));

    // R7: a held cycle makes the output equal the accumulator
    a_r7_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[4] |=> (freq_word == $past(acc_q)));

    // R8: a held cycle leaves the accumulator unchanged
    a_r8_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[4] |=> $stable(acc_q));

    // R10: the accumulator at its top limit stays there on a non-negative error
    a_r10_no_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !ctrl_word[4] && acc_q == LIM_HI && !err_in[ERR_W-1])
        |=> (acc_q == LIM_HI));

    // R10: the accumulator at its bottom limit stays there on a negative error
    a_r10_no_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !ctrl_word[4] && acc_q == LIM_LO && err_in[ERR_W-1])
        |=> (acc_q == LIM_LO));
endmodule

bind pi_loop_filter pi_loop_filter_checker #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_in    (err_in),
    .ctrl_word (ctrl_word),
    .freq_word (freq_word),
    .acc_q     (acc_q)
);

// File: tb/pi_loop_filter_bench.sv
`timescale 1ns/1ps
module pi_loop_filter_bench;
    localparam int ERR_W = 12;
    localparam int ACC_W = 24;
    localparam longint LIM_HI = (longint'(1) <<< (ACC_W-1)) - 1;
    localparam longint LIM_LO = -(longint'(1) <<< (ACC_W-1));

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    err_valid = 1'b0;
    logic signed [ERR_W-1:0] err_in = '0;
    logic [4:0]              ctrl_word = '0;
    logic signed [ACC_W-1:0] freq_word;

    int checks = 0;
    int errors = 0;
    longint m_acc = 0;
    longint m_out = 0;

    always #2.5 clk = ~clk;

    pi_loop_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_pi_loop_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (err_valid),
        .err_in    (err_in),
        .ctrl_word (ctrl_word),
        .freq_word (freq_word)
    );

    function automatic longint clamp(input longint v);
        if (v > LIM_HI) return LIM_HI;
        if (v < LIM_LO) return LIM_LO;
        return v;
    endfunction

    // Detector gain as a shift: R2 codes 00/01/10 -> 0/1/2, R3 code 11 -> 0.
    function automatic int pd_sh(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
    endfunction

    // R4 proportional shift.
    function automatic int p_sh(input logic [1:0] c);
        return 2 * int'(c);
    endfunction

    // R5 integral shift.
    function automatic int i_sh(input logic [1:0] c);
        return (c == 2'b00) ? 12 : (c == 2'b01) ? 8 : (c == 2'b10) ? 5 : 0;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (longint'(freq_word) != m_out) begin
            errors++;
            $display("FAIL %s: freq_word=%0d expected=%0d", tag, freq_word, m_out);
        end
    endtask

    // One sample cycle: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input bit v, input longint e, input logic [1:0] lg,
                        input logic [1:0] pd, input bit hold, input string tag);
        longint es;
        err_valid = v;
        err_in    = e[ERR_W-1:0];
        ctrl_word = {hold, pd, lg};
        @(posedge clk);
        es = e <<< pd_sh(pd);
        if (hold) m_out = m_acc;
        else if (v) begin
            m_acc = clamp(m_acc + (es >>> i_sh(lg)));
            m_out = clamp((es <<< p_sh(lg)) + m_acc);
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        err_valid = 1'b0;
        ctrl_word = '0;
        repeat (3) @(posedge clk);
        m_acc = 0;
        m_out = 0;
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));

        // R1: reset state, also checked after a dirty run later
        do_reset();

        // R2: detector gains x1, x2, x4 with an integral-free view at low gain
        step(1, 100, 2'b00, 2'b00, 0, "R2");
        step(1, 100, 2'b00, 2'b01, 0, "R2");
        step(1, -100, 2'b00, 2'b10, 0, "R2");
        // R3: unused code behaves like x1
        do_reset();
        step(1, 1000, 2'b11, 2'b11, 0, "R3");
        step(1, -777, 2'b10, 2'b11, 0, "R3");

        // R4 and R5: each loop-gain code, positive and negative error (floor rounding)
        for (int c = 0; c < 4; c++) begin
            do_reset();
            step(1, 1500, c[1:0], 2'b00, 0, "R4");
            step(1, -1, c[1:0], 2'b00, 0, "R5");
            step(1, -2000, c[1:0], 2'b10, 0, "R5");
        end

        // R6: idle cycles hold the output
        step(0, 555, 2'b11, 2'b10, 0, "R6");
        step(0, -9, 2'b00, 2'b00, 0, "R6");

        // R7/R8: hold together with valid samples at full gain
        step(1, 2047, 2'b11, 2'b10, 1, "R7");
        step(1, 2047, 2'b11, 2'b10, 1, "R8");
        step(1, -2048, 2'b11, 2'b10, 1, "R8");
        step(0, 0, 2'b11, 2'b10, 1, "R7");
        // R9: release resumes tracking
        step(1, 300, 2'b10, 2'b01, 0, "R9");
        step(1, 300, 2'b10, 2'b01, 0, "R9");

        // R10/R11: drive the accumulator to both limits and beyond
        do_reset();
        for (int i = 0; i < 1100; i++) step(1, 2047, 2'b11, 2'b10, 0, "R11");
        step(1, 2047, 2'b11, 2'b10, 1, "R10");
        step(1, 2047, 2'b11, 2'b10, 0, "R10");
        for (int i = 0; i < 2200; i++) step(1, -2048, 2'b11, 2'b10, 0, "R11");
        step(0, 0, 2'b00, 2'b00, 1, "R10");
        step(1, -2048, 2'b11, 2'b10, 0, "R10");

        // Random traffic mixing samples, idles, holds and gain changes (R6)
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            logic [1:0] lg, pd;
            bit v, h;
            longint e;
            lg = 2'($urandom_range(0, 3));
            pd = 2'($urandom_range(0, 3));
            v  = ($urandom_range(0, 9) < 7);
            h  = ($urandom_range(0, 19) < 3);
            e  = longint'($urandom_range(0, 4095)) - 2048;
            step(v, e, lg, pd, h, h ? "R8" : "R6");
        end

        // R1: reset clears a non-zero state
        do_reset();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule